// File: doc/BRIEF.md
# Issue Window Wakeup and Select

This block is the scheduling core of an out-of-order issue queue. It holds a fixed number of waiting instructions, each described only by two source operand tags, a ready flag per operand and a destination tag. Instructions enter through a single dispatch port and are placed in the lowest-numbered free slot. Each cycle a set of result tags is broadcast; every stored operand compares its tag with all of them in parallel and becomes ready on any match.

Once both operands of a slot are ready, the slot raises a request. A tree of four-input arbiter cells passes requests upward and grants downward, and several such selection stages are chained so that each functional unit gets one grant, with later stages blind to slots already granted by earlier ones. Wakeup and selection happen in the same cycle, so an instruction whose last operand arrives on the broadcast bus can be granted in that cycle. A granted slot is freed at the next clock edge and its destination tag is presented at the outputs, to be broadcast later by the surrounding pipeline.

Top module: `issue_window`

## Requirements
- R1: After reset no slot is occupied: every grant valid output is 0 and `disp_ready` is 1.
- R2: A dispatch with `disp_valid` high and `disp_ready` high is written into the lowest-indexed free slot at the clock edge; `disp_ready` is 0 when all slots are occupied, and a dispatch offered then is dropped.
- R3: A stored operand becomes ready when its tag equals the tag of any broadcast lane whose valid bit is 1, and it stays ready until the slot is freed.
- R4: A slot requests issue when it is occupied and both operands are ready, counting matches from broadcasts of the same cycle, so a grant can appear in the cycle its last operand is woken.
- R5: Selection stage k (k = 0 first, lowest bits of `gnt_valid`, `gnt_idx`, `gnt_dst`) grants the lowest-indexed requesting slot not granted by stages 0..k-1; slot index fields are IDXW bits each, destination fields TAGW bits each.
- R6: A granted slot is freed at the next clock edge and is not granted again.
- R7: An operand dispatched in the same cycle as a matching valid broadcast is stored as ready.
- R8: A broadcast lane whose valid bit is 0 wakes no operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_tag_l | input | TAGW | Left source tag |
| disp_tag_r | input | TAGW | Right source tag |
| disp_rdy_l | input | 1 | Left operand already available |
| disp_rdy_r | input | 1 | Right operand already available |
| disp_dst | input | TAGW | Destination tag |
| disp_ready | output | 1 | A free slot exists |
| bcast_valid | input | IW | Valid bit per broadcast lane |
| bcast_tag | input | IW*TAGW | Broadcast result tags, lane 0 in low bits |
| gnt_valid | output | NFU | Grant per selection stage |
| gnt_idx | output | NFU*IDXW | Granted slot index per stage |
| gnt_dst | output | NFU*TAGW | Destination tag of granted slot per stage |

## Verification
The wakeup path is driven with tags arriving on either broadcast lane, with one operand pre-ready and with none, and with a matching tag on an invalid lane, which separates lane-valid gating from pure tag compare. A broadcast coinciding with dispatch distinguishes write-time wakeup from wakeup of stored entries only. Filling the window and then waking every slot at once yields eight simultaneous requesters, which shows the stage cascade picking the two lowest indices per cycle and the freed slots dropping out, while a dispatch offered to the full window must never surface as a later grant.

// File: rtl/issue_window.sv
module issue_window #(
  parameter int WINSIZE = 8,
  parameter int IW      = 2,
  parameter int NFU     = 2,
  parameter int TAGW    = 6,
  localparam int IDXW   = $clog2(WINSIZE)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 disp_valid,
  input  logic [TAGW-1:0]      disp_tag_l,
  input  logic [TAGW-1:0]      disp_tag_r,
  input  logic                 disp_rdy_l,
  input  logic                 disp_rdy_r,
  input  logic [TAGW-1:0]      disp_dst,
  output logic                 disp_ready,
  input  logic [IW-1:0]        bcast_valid,
  input  logic [IW*TAGW-1:0]   bcast_tag,
  output logic [NFU-1:0]       gnt_valid,
  output logic [NFU*IDXW-1:0]  gnt_idx,
  output logic [NFU*TAGW-1:0]  gnt_dst
);

  localparam int LV = ($clog2(WINSIZE) + 1) / 2;
  localparam int P  = 1 << (2 * LV);

  logic [WINSIZE-1:0] valid_q, rdy_l_q, rdy_r_q;
  logic [TAGW-1:0]    tag_l_q [WINSIZE];
  logic [TAGW-1:0]    tag_r_q [WINSIZE];
  logic [TAGW-1:0]    dst_q   [WINSIZE];

  logic [WINSIZE-1:0] hit_l, hit_r, eff_l, eff_r, req, gnt_all;
  logic               dhit_l, dhit_r;
  logic [IDXW-1:0]    free_idx;
  logic               disp_fire;

  always_comb begin
    for (int i = 0; i < WINSIZE; i++) begin
      hit_l[i] = 1'b0;
      hit_r[i] = 1'b0;
      for (int b = 0; b < IW; b++) begin
        if (bcast_valid[b] && bcast_tag[b*TAGW +: TAGW] == tag_l_q[i]) hit_l[i] = 1'b1;
        if (bcast_valid[b] && bcast_tag[b*TAGW +: TAGW] == tag_r_q[i]) hit_r[i] = 1'b1;
      end
    end
    dhit_l = 1'b0;
    dhit_r = 1'b0;
    for (int b = 0; b < IW; b++) begin
      if (bcast_valid[b] && bcast_tag[b*TAGW +: TAGW] == disp_tag_l) dhit_l = 1'b1;
      if (bcast_valid[b] && bcast_tag[b*TAGW +: TAGW] == disp_tag_r) dhit_r = 1'b1;
    end
  end

  assign eff_l = rdy_l_q | hit_l;
  assign eff_r = rdy_r_q | hit_r;
  assign req   = valid_q & eff_l & eff_r;

  always_comb begin
    free_idx = '0;
    for (int i = WINSIZE - 1; i >= 0; i--)
      if (!valid_q[i]) free_idx = IDXW'(i);
  end

  assign disp_ready = ~&valid_q;
  assign disp_fire  = disp_valid & disp_ready;

  function automatic logic [P-1:0] tree_pick(input logic [P-1:0] r);
    logic any_n [LV+1][P];
    logic en_n  [LV+1][P];
    logic seen;
    for (int k = 0; k <= LV; k++)
      for (int j = 0; j < P; j++) begin
        any_n[k][j] = 1'b0;
        en_n[k][j]  = 1'b0;
      end
    for (int j = 0; j < P; j++) any_n[0][j] = r[j];
    for (int k = 1; k <= LV; k++)
      for (int j = 0; j < (P >> (2 * k)); j++)
        any_n[k][j] = any_n[k-1][4*j] | any_n[k-1][4*j+1] |
                      any_n[k-1][4*j+2] | any_n[k-1][4*j+3];
    en_n[LV][0] = any_n[LV][0];
    for (int k = LV; k >= 1; k--)
      for (int j = 0; j < (P >> (2 * k)); j++) begin
        seen = 1'b0;
        for (int c = 0; c < 4; c++) begin
          en_n[k-1][4*j+c] = en_n[k][j] & any_n[k-1][4*j+c] & ~seen;
          seen = seen | any_n[k-1][4*j+c];
        end
      end
    for (int j = 0; j < P; j++) tree_pick[j] = en_n[0][j];
  endfunction

  logic [WINSIZE-1:0] taken [NFU+1];
  logic [WINSIZE-1:0] stage_g [NFU];
  assign taken[0] = '0;

  for (genvar s = 0; s < NFU; s++) begin : g_stage
    logic [P-1:0] pick;
    logic [IDXW-1:0] enc;
    assign pick         = tree_pick(P'(req & ~taken[s]));
    assign stage_g[s]   = pick[WINSIZE-1:0];
    assign taken[s+1]   = taken[s] | stage_g[s];
    always_comb begin
      enc = '0;
      for (int i = 0; i < WINSIZE; i++)
        if (stage_g[s][i]) enc = IDXW'(i);
    end
    assign gnt_valid[s]               = |stage_g[s];
    assign gnt_idx[s*IDXW +: IDXW]    = enc;
    assign gnt_dst[s*TAGW +: TAGW]    = dst_q[enc];

    AST_STAGE_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid[s] |-> ((req & ~taken[s] & ~({WINSIZE{1'b1}} << enc)) == '0)); // R5
    AST_GRANT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid[s] |-> (valid_q[enc] && eff_l[enc] && eff_r[enc])); // R4
  end

  assign gnt_all = taken[NFU];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      rdy_l_q <= '0;
      rdy_r_q <= '0;
    end else begin
      for (int i = 0; i < WINSIZE; i++) begin
        if (gnt_all[i]) begin
          valid_q[i] <= 1'b0;
        end else if (disp_fire && free_idx == IDXW'(i)) begin
          valid_q[i] <= 1'b1;
          rdy_l_q[i] <= disp_rdy_l | dhit_l;
          rdy_r_q[i] <= disp_rdy_r | dhit_r;
          tag_l_q[i] <= disp_tag_l;
          tag_r_q[i] <= disp_tag_r;
          dst_q[i]   <= disp_dst;
        end else if (valid_q[i]) begin
          rdy_l_q[i] <= eff_l[i];
          rdy_r_q[i] <= eff_r[i];
        end
      end
    end
  end

  AST_GRANT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gnt_all) == $countones(gnt_valid)); // R5
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_ready && gnt_all == '0) |=> (&valid_q)); // R2

  for (genvar i = 0; i < WINSIZE; i++) begin : g_chk
    AST_GRANT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_all[i] |=> !valid_q[i]); // R6
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q[i] && rdy_l_q[i] && !gnt_all[i]) |=> rdy_l_q[i]); // R3
  end

endmodule

// File: tb/issue_window_tb.sv
module issue_window_tb;
  localparam int WINSIZE = 8, IW = 2, NFU = 2, TAGW = 6, IDXW = 3;

  logic clk = 0, rst_n = 0;
  logic disp_valid = 0, disp_rdy_l = 0, disp_rdy_r = 0, disp_ready;
  logic [TAGW-1:0] disp_tag_l = 0, disp_tag_r = 0, disp_dst = 0;
  logic [IW-1:0] bcast_valid = 0;
  logic [IW*TAGW-1:0] bcast_tag = 0;
  logic [NFU-1:0] gnt_valid;
  logic [NFU*IDXW-1:0] gnt_idx;
  logic [NFU*TAGW-1:0] gnt_dst;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  issue_window #(.WINSIZE(WINSIZE), .IW(IW), .NFU(NFU), .TAGW(TAGW)) u_dut (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_tag_l(disp_tag_l),
    .disp_tag_r(disp_tag_r), .disp_rdy_l(disp_rdy_l), .disp_rdy_r(disp_rdy_r),
    .disp_dst(disp_dst), .disp_ready(disp_ready), .bcast_valid(bcast_valid),
    .bcast_tag(bcast_tag), .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .gnt_dst(gnt_dst));

  typedef struct packed {
    logic dv; logic [5:0] tl, tr; logic rl, rr; logic [5:0] dst;
    logic [1:0] bv; logic [5:0] bt0, bt1;
    logic [1:0] egv; logic [2:0] ei0, ei1; logic [5:0] ed0, ed1; logic edr;
  } vec_t;

  localparam vec_t TBL [11] = '{
    '{1, 1, 2, 1, 1, 10, 0, 0, 0,  0, 0, 0,  0,  0, 1},
    '{0, 0, 0, 0, 0,  0, 0, 0, 0,  1, 0, 0, 10,  0, 1},
    '{0, 0, 0, 0, 0,  0, 0, 0, 0,  0, 0, 0,  0,  0, 1},
    '{1, 3, 4, 0, 0, 11, 0, 0, 0,  0, 0, 0,  0,  0, 1},
    '{1, 3, 1, 0, 1, 12, 1, 4, 0,  0, 0, 0,  0,  0, 1},
    '{0, 0, 0, 0, 0,  0, 2, 0, 3,  3, 0, 1, 11, 12, 1},
    '{0, 0, 0, 0, 0,  0, 0, 0, 0,  0, 0, 0,  0,  0, 1},
    '{1, 5, 6, 0, 0, 13, 2, 5, 6,  0, 0, 0,  0,  0, 1},
    '{0, 0, 0, 0, 0,  0, 2, 5, 0,  0, 0, 0,  0,  0, 1},
    '{0, 0, 0, 0, 0,  0, 1, 5, 0,  1, 0, 0, 13,  0, 1},
    '{0, 0, 0, 0, 0,  0, 0, 0, 0,  0, 0, 0,  0,  0, 1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic [1:0] egv, input logic [2:0] ei0,
                           input logic [2:0] ei1, input logic [5:0] ed0, input logic [5:0] ed1,
                           input logic edr);
    chk({req, " gnt_valid"}, 32'(gnt_valid), 32'(egv));
    if (egv[0]) begin
      chk({req, " idx0"}, 32'(gnt_idx[2:0]), 32'(ei0));
      chk({req, " dst0"}, 32'(gnt_dst[5:0]), 32'(ed0));
    end
    if (egv[1]) begin
      chk({req, " idx1"}, 32'(gnt_idx[5:3]), 32'(ei1));
      chk({req, " dst1"}, 32'(gnt_dst[11:6]), 32'(ed1));
    end
    chk({req, " disp_ready"}, 32'(disp_ready), 32'(edr));
  endtask

  task automatic drive(input logic dv, input logic [5:0] tl, input logic [5:0] tr,
                       input logic rl, input logic rr, input logic [5:0] dst,
                       input logic [1:0] bv, input logic [5:0] bt0, input logic [5:0] bt1);
    disp_valid = dv; disp_tag_l = tl; disp_tag_r = tr;
    disp_rdy_l = rl; disp_rdy_r = rr; disp_dst = dst;
    bcast_valid = bv; bcast_tag = {bt1, bt0};
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1 check_out("R1 reset", 0, 0, 0, 0, 0, 1);

    // R3 R4 R5 R6 R7 R8 sequence
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      drive(TBL[i].dv, TBL[i].tl, TBL[i].tr, TBL[i].rl, TBL[i].rr, TBL[i].dst,
            TBL[i].bv, TBL[i].bt0, TBL[i].bt1);
      #1 check_out($sformatf("R3/R4/R5/R6/R7/R8 row%0d", i), TBL[i].egv, TBL[i].ei0,
                   TBL[i].ei1, TBL[i].ed0, TBL[i].ed1, TBL[i].edr);
    end

    // R2 fill the window
    for (int i = 0; i < WINSIZE; i++) begin
      @(negedge clk);
      drive(1, 20, 20, 0, 0, 6'(30 + i), 0, 0, 0);
      #1 chk("R2 ready while filling", 32'(disp_ready), 1);
    end
    @(negedge clk);
    drive(1, 1, 1, 1, 1, 50, 0, 0, 0);
    #1 chk("R2 full", 32'(disp_ready), 0);
    chk("R2 no grant while waiting", 32'(gnt_valid), 0);
    @(negedge clk);
    drive(0, 0, 0, 0, 0, 0, 2'b10, 0, 20);
    #1 check_out("R5 wake all", 3, 0, 1, 30, 31, 0);
    @(negedge clk);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    #1 check_out("R6 R5 drain 2", 3, 2, 3, 32, 33, 1);
    @(negedge clk);
    #1 check_out("R6 drain 4", 3, 4, 5, 34, 35, 1);
    @(negedge clk);
    #1 check_out("R6 drain 6", 3, 6, 7, 36, 37, 1);
    @(negedge clk);
    #1 check_out("R2 dropped dispatch absent", 0, 0, 0, 0, 0, 1);

    // R1 reset clears a pending ready entry
    @(negedge clk);
    drive(1, 1, 1, 1, 1, 9, 0, 0, 0);
    @(negedge clk);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    #1 check_out("R1 reset clears", 0, 0, 0, 0, 0, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule